// File: doc/BRIEF.md
# Merging Store Buffer

This block sits between the processor store path and memory. It holds a small number of pending writes. Each pending entry covers one block-aligned address and keeps one data word and one valid bit per word slot. A store to a block that is already pending is folded into that entry. Any other store takes a fresh entry. When every entry is taken and the store cannot be folded, the store interface is stalled.

Stores that fall in a configurable I/O address window are never folded. Each one gets an entry of its own, and no later store is folded into it. Entries leave through a drain port in the order they were allocated. One valid/ready handshake moves the block address, all word data and the word-valid mask together. The store side keeps running while the drain side works.

Addresses are word addresses. The low log2(WORDS) bits select the word slot, and the upper bits form the block address.

Top module: `mwb_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `empty`=1, `dr_valid`=0 and `st_stall`=0 (given `st_valid`=0).
- R2: A store is folded into a pending entry when all of these hold: the store is not an I/O store, the entry is not an I/O entry, and its block address equals `st_addr[AW-1:WB]`. The fold writes `st_data` into word slot `st_addr[WB-1:0]` and sets mask bit number `st_addr[WB-1:0]`. No new entry is taken, and the fold is never stalled.
- R3: A store that cannot be folded, with at least one free entry, takes a new entry at the tail. That entry's mask has only bit `st_addr[WB-1:0]` set. Mask bit i marks word i, which lies at `dr_data[i*DW +: DW]`. Data in slots with a clear mask bit is don't-care.
- R4: `st_stall` is 1 in a cycle exactly when `st_valid`=1, the store cannot be folded, and all ENTRIES entries are occupied. A stalled store changes nothing.
- R5: A store whose word address lies in [IO_LO, IO_HI] never folds and is never folded into. Two I/O stores to the same word therefore drain as two separate single-word entries.
- R6: `dr_valid` is 1 whenever an entry is pending. The drain port shows the oldest entry: `dr_addr` (block address), `dr_data` and `dr_mask`. The entry leaves on a cycle with `dr_valid` and `dr_ready` both high, and entries leave in allocation order.
- R7: A store that matches the oldest entry in the same cycle in which that entry drains does not fold into it. It takes a new entry instead, or stalls if R4 applies.
- R8: `empty` is 1 exactly when no entry is pending.
- R9: Drain activity never stalls a store except through R4 and R7. Stores are taken in cycles that also drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request present |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data word |
| st_stall | output | 1 | Store not taken this cycle |
| dr_valid | output | 1 | Oldest entry offered to memory |
| dr_ready | input | 1 | Memory takes the offered entry |
| dr_addr | output | AW-log2(WORDS) | Block address of oldest entry |
| dr_data | output | WORDS*DW | Word data of oldest entry, word i at bits i*DW |
| dr_mask | output | WORDS | Word-valid mask of oldest entry |
| empty | output | 1 | No entry pending |

## Verification
The assertions assume that the memory side takes an offered entry only through the handshake. They also assume that a held `dr_valid` is not withdrawn by the environment, since the block alone owns that signal. The properties on the drained mask rest on I/O stores being identified only by their word address. The stimulus keeps all addresses within a handful of ordinary blocks plus part of the I/O window, so that folding, stalling and I/O separation happen often. It changes inputs only half a cycle away from the active edge and raises `dr_ready` freely, including while the buffer is full.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
  function automatic logic in_window(input logic [31:0] a, input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/mwb_ptrs.sv
module mwb_ptrs #(
  parameter int ENTRIES = 4,
  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CW = $clog2(ENTRIES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          none
);
  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= step(tail);
      if (pop)  head <= step(head);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign full = (count == CW'(ENTRIES));
  assign none = (count == '0);
endmodule

// File: rtl/mwb_match.sv
module mwb_match #(
  parameter int ENTRIES = 4,
  parameter int BW = 14,
  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [BW-1:0]      blk,
  input  logic               st_io,
  input  logic [BW-1:0]      e_blk [ENTRIES],
  input  logic [ENTRIES-1:0] e_live,
  input  logic [ENTRIES-1:0] e_io,
  input  logic [PW-1:0]      head,
  input  logic               head_leaving,
  output logic               any_hit,
  output logic [PW-1:0]      hit_idx
);
  logic [ENTRIES-1:0] hit;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit[i] = e_live[i] && !e_io[i] && !st_io && (e_blk[i] == blk) &&
                    !(head_leaving && (head == PW'(i)));
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) hit_idx = PW'(i);
    end
  end

  assign any_hit = |hit;
endmodule

// File: rtl/mwb_top.sv
module mwb_top #(
  parameter int          AW      = 16,
  parameter int          DW      = 32,
  parameter int          WORDS   = 4,
  parameter int          ENTRIES = 4,
  parameter int unsigned IO_LO   = 32'h0000_F000,
  parameter int unsigned IO_HI   = 32'h0000_FFFF,
  localparam int WB = $clog2(WORDS),
  localparam int BW = AW - WB,
  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CW = $clog2(ENTRIES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                st_valid,
  input  logic [AW-1:0]       st_addr,
  input  logic [DW-1:0]       st_data,
  output logic                st_stall,
  output logic                dr_valid,
  input  logic                dr_ready,
  output logic [BW-1:0]       dr_addr,
  output logic [WORDS*DW-1:0] dr_data,
  output logic [WORDS-1:0]    dr_mask,
  output logic                empty
);
  logic [BW-1:0]      e_blk  [ENTRIES];
  logic [DW-1:0]      e_data [ENTRIES][WORDS];
  logic [WORDS-1:0]   e_mask [ENTRIES];
  logic [ENTRIES-1:0] e_io;
  logic [ENTRIES-1:0] e_live;

  logic [PW-1:0] head, tail, hit_idx;
  logic [CW-1:0] count;
  logic          full, none, any_hit;
  logic          drain_fire, do_merge, do_alloc, st_io;
  logic [BW-1:0] st_blk;
  logic [WB-1:0] st_word;

  assign st_blk  = st_addr[AW-1:WB];
  assign st_word = st_addr[WB-1:0];
  assign st_io   = mwb_pkg::in_window(32'(st_addr), IO_LO, IO_HI);

  assign dr_valid   = !none;
  assign empty      = none;
  assign drain_fire = dr_valid && dr_ready;

  mwb_match #(.ENTRIES(ENTRIES), .BW(BW)) u_match (
    .blk(st_blk), .st_io(st_io), .e_blk(e_blk), .e_live(e_live), .e_io(e_io),
    .head(head), .head_leaving(drain_fire), .any_hit(any_hit), .hit_idx(hit_idx)
  );

  assign do_merge = st_valid && any_hit;
  assign do_alloc = st_valid && !any_hit && !full;
  assign st_stall = st_valid && !any_hit && full;

  mwb_ptrs #(.ENTRIES(ENTRIES)) u_ptrs (
    .clk(clk), .rst(rst), .push(do_alloc), .pop(drain_fire),
    .head(head), .tail(tail), .count(count), .full(full), .none(none)
  );

  // control state with reset
  always_ff @(posedge clk) begin
    if (rst) begin
      e_live <= '0;
      e_io   <= '0;
      for (int i = 0; i < ENTRIES; i++) e_mask[i] <= '0;
    end else begin
      if (drain_fire) e_live[head] <= 1'b0;
      if (do_merge) e_mask[hit_idx][st_word] <= 1'b1;
      if (do_alloc) begin
        e_live[tail] <= 1'b1;
        e_io[tail]   <= st_io;
        e_mask[tail] <= WORDS'(1) << st_word;
      end
    end
  end

  // payload storage, no reset
  always_ff @(posedge clk) begin
    if (do_alloc) begin
      e_blk[tail]           <= st_blk;
      e_data[tail][st_word] <= st_data;
    end
    if (do_merge) e_data[hit_idx][st_word] <= st_data;
  end

  assign dr_addr = e_blk[head];
  assign dr_mask = e_mask[head];
  for (genvar w = 0; w < WORDS; w++) begin : g_out
    assign dr_data[w*DW +: DW] = e_data[head][w];
  end
endmodule

// File: rtl/mwb_chk.sv
module mwb_chk #(
  parameter int          WORDS   = 4,
  parameter int          ENTRIES = 4,
  parameter int          BW      = 14,
  parameter int          CW      = 3,
  parameter int unsigned IO_LO   = 32'h0000_F000,
  parameter int unsigned IO_HI   = 32'h0000_FFFF
) (
  input logic             clk,
  input logic             rst,
  input logic             st_valid,
  input logic             st_stall,
  input logic             dr_valid,
  input logic             dr_ready,
  input logic [BW-1:0]    dr_addr,
  input logic [WORDS-1:0] dr_mask,
  input logic             empty,
  input logic [CW-1:0]    count
);
  localparam int WB = $clog2(WORDS);
  localparam int unsigned IOB_LO = IO_LO >> WB;
  localparam int unsigned IOB_HI = IO_HI >> WB;

  a_r4_stall_needs_store: assert property (@(posedge clk) disable iff (rst)
    st_stall |-> st_valid);
  a_r4_stall_only_full: assert property (@(posedge clk) disable iff (rst)
    st_stall |-> (count == CW'(ENTRIES)));
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(ENTRIES));
  a_r6_head_holds: assert property (@(posedge clk) disable iff (rst)
    dr_valid && !dr_ready |=> dr_valid && $stable(dr_addr));
  a_r3_mask_nonzero: assert property (@(posedge clk) disable iff (rst)
    dr_valid |-> (dr_mask != '0));
  a_r5_io_single_word: assert property (@(posedge clk) disable iff (rst)
    dr_valid && (32'(dr_addr) >= IOB_LO) && (32'(dr_addr) <= IOB_HI) |-> $onehot(dr_mask));
  a_r8_empty_persists: assert property (@(posedge clk) disable iff (rst)
    empty && !st_valid |=> empty);
endmodule

bind mwb_top mwb_chk #(.WORDS(WORDS), .ENTRIES(ENTRIES), .BW(BW), .CW(CW),
                       .IO_LO(IO_LO), .IO_HI(IO_HI)) u_chk (
  .clk(clk), .rst(rst), .st_valid(st_valid), .st_stall(st_stall),
  .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
  .dr_mask(dr_mask), .empty(empty), .count(count)
);

// File: tb/tb_mwb_top.sv
`timescale 1ns/1ps
module tb_mwb_top;
  localparam int AW = 16, DW = 32, WORDS = 4, ENTRIES = 4;

  logic clk = 0, rst = 1;
  logic st_valid = 0, dr_ready = 0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic st_stall, dr_valid, empty;
  logic [AW-3:0] dr_addr;
  logic [WORDS*DW-1:0] dr_data;
  logic [WORDS-1:0] dr_mask;

  always #2 clk = ~clk;

  mwb_top dut (.clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_stall(st_stall), .dr_valid(dr_valid), .dr_ready(dr_ready),
    .dr_addr(dr_addr), .dr_data(dr_data), .dr_mask(dr_mask), .empty(empty));

  typedef struct { int blk; logic [DW-1:0] d [WORDS]; logic [WORDS-1:0] m; bit io; } ent_t;
  ent_t q[$];
  int vectors = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare with model, advance model
  task automatic step(input bit v, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit rdy, input string tag);
    bit sio, drain, estall;
    int blk, w, j, sz;
    @(negedge clk);
    st_valid = v; st_addr = a; st_data = d; dr_ready = rdy;
    #1;
    sio = (a >= 16'hF000);
    blk = int'(a >> 2); w = int'(a[1:0]);
    sz = q.size();
    drain = (sz > 0) && rdy;
    j = -1;
    if (v && !sio)
      for (int k = 0; k < sz; k++)
        if (j < 0 && !q[k].io && q[k].blk == blk && !(k == 0 && drain)) j = k;
    estall = v && (j < 0) && (sz == ENTRIES);
    chk(st_stall == estall, tag, "R4 stall", 128'(st_stall), 128'(estall));
    chk(empty == (sz == 0), tag, "R8 empty", 128'(empty), 128'(sz == 0));
    chk(dr_valid == (sz > 0), tag, "R6 dr_valid", 128'(dr_valid), 128'(sz > 0));
    if (sz > 0) begin
      chk(int'(dr_addr) == q[0].blk, tag, "R6 dr_addr", 128'(dr_addr), 128'(q[0].blk));
      chk(dr_mask == q[0].m, tag, "R3 dr_mask", 128'(dr_mask), 128'(q[0].m));
      for (int i = 0; i < WORDS; i++)
        if (q[0].m[i])
          chk(dr_data[i*DW +: DW] == q[0].d[i], tag, "R2 dr_data word",
              128'(dr_data[i*DW +: DW]), 128'(q[0].d[i]));
    end
    if (v && j >= 0) begin q[j].d[w] = d; q[j].m[w] = 1'b1; end
    if (drain) void'(q.pop_front());
    if (v && j < 0 && sz < ENTRIES) begin
      ent_t e;
      e.blk = blk; e.io = sio; e.m = '0; e.m[w] = 1'b1;
      for (int i = 0; i < WORDS; i++) e.d[i] = '0;
      e.d[w] = d;
      q.push_back(e);
    end
    @(posedge clk);
  endtask

  initial begin
    int r;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(empty == 1 && dr_valid == 0 && st_stall == 0, "R1", "reset outputs",
        128'({empty, dr_valid, st_stall}), 128'(3'b100));
    rst = 0;
    step(0, 0, 0, 0, "R1");
    // R2: four words folded into one block
    for (int i = 0; i < 4; i++) step(1, 16'h0010 + 16'(i), 32'hA0 + i, 0, "R2");
    step(1, 16'h0012, 32'hBEEF, 0, "R2");
    // R3: new blocks
    step(1, 16'h0025, 32'h25, 0, "R3");
    // R5: same I/O word twice
    step(1, 16'hF004, 32'h1, 0, "R5");
    step(1, 16'hF004, 32'h2, 0, "R5");
    // R4: full, non-folding store stalls; folding store still taken
    step(1, 16'h0030, 32'h30, 0, "R4");
    step(1, 16'hF008, 32'h3, 0, "R4");
    step(1, 16'h0013, 32'hCC, 0, "R4");
    // R7: store to head block while head drains (full -> stall)
    step(1, 16'h0011, 32'hDD, 1, "R7");
    // R9: drain and store together
    step(1, 16'h0040, 32'h40, 1, "R9");
    step(1, 16'h0026, 32'h26, 1, "R7");
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, "R6");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] a;
      r = $urandom_range(0, 9);
      if (r < 2) a = 16'hF000 + 16'($urandom_range(0, 7));
      else a = 16'($urandom_range(0, 23));
      step($urandom_range(0, 3) != 0, a, $urandom,
           (n % 600 < 300) ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 3) != 0),
           "R2");
    end
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, "R8");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(100000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule